// File: doc/BRIEF.md
# Selectable-Ratio PLL Frequency Comparator

This block is the digital comparison path of an integer-N frequency synthesizer. It takes a VCO signal and a reference signal and divides each by a ratio. A single mode pin selects the ratio, and the two ratios always switch together as a fixed pair. The two divided event streams go to a phase-frequency detector. The detector produces pump enables that model a three-state charge-pump pin: one enable drives the pin high, one drives it low, and with both off the pin floats. A polarity pin picks which pump direction corrects a fast reference. The same pin also picks which divided signal goes to a monitor output. A lock flag reports when the detector pulses have stayed narrow for long enough.

Everything runs on one sampling clock `clk`. Both `vcoIn` and `refIn` are treated as level inputs that are synchronous to `clk`, and a rising edge is a 0 sample followed by a 1 sample. Each input must stay high for at least one clock cycle and low for at least one clock cycle. Pulse widths are measured in `clk` cycles.

Top module: `pll_cmp_core`

## Requirements
- R1: With `modeSel`=1, every 338th rising edge of `vcoIn` is a VCO divided event, and every 4th rising edge of `refIn` is a reference divided event.
- R2: With `modeSel`=0, the VCO ratio is 570 and the reference ratio is 6.
- R3: Each divider counts rising edges from 0 up to ratio-1 and then wraps to 0. The wrap is its divided event. Its divided output is 1 while the count is below ratio/2 and 0 otherwise. Reset and a mode change both set the count to 0.
- R4: `testOut` carries the reference divided output when `polSel`=1 and the VCO divided output when `polSel`=0.
- R5: With `polSel`=1, a reference event that arrives before the matching VCO event asserts `pumpLow`. A VCO event that arrives first asserts `pumpHigh`. The enable stays asserted from the cycle after the leading event until the cycle after the trailing event.
- R6: With `polSel`=0, the mapping is swapped: a leading reference event asserts `pumpHigh`, and a leading VCO event asserts `pumpLow`.
- R7: `pumpHigh` and `pumpLow` are never both 1. When the two divided events fall in the same cycle, neither enable asserts, so the pin stays high impedance.
- R8: `lockFlag` rises on the `LOCK_COUNT`-th consecutive reference divided event (default 8) such that no pump pulse in those comparison periods lasted more than `WIDE_LIM` cycles (default 4).
- R9: If a pump pulse lasts more than `WIDE_LIM` cycles, `lockFlag` clears on the next clock edge.
- R10: A change of `modeSel` clears both divider counts, both detector states and `lockFlag` at the next clock edge.
- R11: After reset, `pumpHigh`=0, `pumpLow`=0, `lockFlag`=0 and `testOut`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vcoIn | input | 1 | VCO signal, synchronous to clk |
| refIn | input | 1 | Reference signal, synchronous to clk |
| modeSel | input | 1 | Ratio pair: 1 gives 338/4, 0 gives 570/6 |
| polSel | input | 1 | Pump polarity and monitor source select |
| pumpHigh | output | 1 | Drive the pump pin high |
| pumpLow | output | 1 | Drive the pump pin low |
| testOut | output | 1 | Monitor of one divided signal |
| lockFlag | output | 1 | Loop lock indicator |

## Verification
The stimulus generators give aligned frequencies, a reference that is too fast, and a reference that is too slow, each under both polarity settings. The resulting pump patterns separate a polarity swap from a lead/lag swap. Two phase offsets are applied at matched frequency. A 2-cycle lag has to keep the pump pulsing while still allowing lock, and a 20-cycle lag has to prevent lock, which pins down the width limit. Monitor-period measurements with distinct reference and VCO rates show which divider reaches `testOut` and which ratio is in use. A mid-run frequency step and a mode flip confirm that the lock flag drops.

// File: rtl/pll_cmp_pkg.sv
package pll_cmp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
  } ctrlStrobe_t;

  // Detector state reported from datapath to control
  typedef struct packed {
    logic refTick;
    logic refLead;
    logic vcoLead;
  } pfdStatus_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pcc_divider.sv
module pcc_divider #(
  parameter int DIV_HI = 338,
  parameter int DIV_LO = 570,
  parameter int CNT_W  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic divSel,
  input  logic sigIn,
  output logic tick,
  output logic divOut
);

  logic             prevIn;
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] halfRatio;

  assign ratio     = divSel ? CNT_W'(DIV_HI) : CNT_W'(DIV_LO);
  assign halfRatio = ratio >> 1;
  assign rise      = sigIn & ~prevIn;
  assign tick      = rise && (cnt == (ratio - CNT_W'(1)));
  assign divOut    = (cnt < halfRatio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= 1'b0;
      cnt    <= '0;
    end else begin
      prevIn <= sigIn;
      if (clear)     cnt <= '0;
      else if (tick) cnt <= '0;
      else if (rise) cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: the count stays inside the selected ratio
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rstN || clear)
    cnt < ratio);

  // R3: a divided event returns the count to zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cnt == '0));

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pll_cmp_pkg::*;
#(
  parameter int VCO_DIV_HI = 338,
  parameter int REF_DIV_HI = 4,
  parameter int VCO_DIV_LO = 570,
  parameter int REF_DIV_LO = 6,
  parameter int CNT_W      = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vcoIn,
  input  logic        refIn,
  input  logic        modeSel,
  input  ctrlStrobe_t strobe,
  output pfdStatus_t  status,
  output logic        vcoDiv,
  output logic        refDiv
);

  localparam int NUM_CH = 2;
  localparam int VCO_CH = 0;
  localparam int REF_CH = 1;

  logic [NUM_CH-1:0] chIn;
  logic [NUM_CH-1:0] chTick;
  logic [NUM_CH-1:0] chDiv;
  logic              refLead;
  logic              vcoLead;
  logic              refNext;
  logic              vcoNext;

  assign chIn[VCO_CH] = vcoIn;
  assign chIn[REF_CH] = refIn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
    localparam int HI = (ch == VCO_CH) ? VCO_DIV_HI : REF_DIV_HI;
    localparam int LO = (ch == VCO_CH) ? VCO_DIV_LO : REF_DIV_LO;
    pcc_divider #(
      .DIV_HI(HI),
      .DIV_LO(LO),
      .CNT_W (CNT_W)
    ) u_div (
      .clk   (clk),
      .rstN  (rstN),
      .clear (strobe.clearAll),
      .divSel(modeSel),
      .sigIn (chIn[ch]),
      .tick  (chTick[ch]),
      .divOut(chDiv[ch])
    );
  end

  // Edge-set detector pair; both set means the pair resets
  assign refNext = refLead | chTick[REF_CH];
  assign vcoNext = vcoLead | chTick[VCO_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLead <= 1'b0;
      vcoLead <= 1'b0;
    end else if (strobe.clearAll || (refNext && vcoNext)) begin
      refLead <= 1'b0;
      vcoLead <= 1'b0;
    end else begin
      refLead <= refNext;
      vcoLead <= vcoNext;
    end
  end

  assign status.refTick = chTick[REF_CH];
  assign status.refLead = refLead;
  assign status.vcoLead = vcoLead;
  assign vcoDiv         = chDiv[VCO_CH];
  assign refDiv         = chDiv[REF_CH];

  // R7: the two detector flops are never set together
  p_lead_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(refLead && vcoLead));

  // R7: coincident events from rest leave the detector at rest
  p_coincide_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chTick[REF_CH] && chTick[VCO_CH] && !refLead && !vcoLead) |=> !(refLead || vcoLead));

  // R10: the clear strobe empties the detector
  p_clear_pfd_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !(refLead || vcoLead));

endmodule

// File: rtl/pcc_control.sv
module pcc_control
  import pll_cmp_pkg::*;
#(
  parameter int WIDE_LIM   = 4,
  parameter int LOCK_COUNT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeSel,
  input  logic        polSel,
  input  pfdStatus_t  status,
  input  logic        vcoDiv,
  input  logic        refDiv,
  output ctrlStrobe_t strobe,
  output logic        pumpHigh,
  output logic        pumpLow,
  output logic        testOut,
  output logic        lockFlag
);

  localparam int PW_W   = $clog2(WIDE_LIM + 1);
  localparam int GOOD_W = (LOCK_COUNT > 2) ? $clog2(LOCK_COUNT) : 1;

  logic              modePrev;
  logic              modeChange;
  logic              active;
  logic              wideNow;
  logic              periodBad;
  logic [PW_W-1:0]   pwCnt;
  logic [GOOD_W-1:0] goodCnt;

  assign modeChange      = (modeSel != modePrev);
  assign strobe.clearAll = modeChange;

  // Polarity mapping and monitor source
  assign pumpLow  = polSel ? status.refLead : status.vcoLead;
  assign pumpHigh = polSel ? status.vcoLead : status.refLead;
  assign testOut  = polSel ? refDiv : vcoDiv;

  assign active  = status.refLead | status.vcoLead;
  assign wideNow = active && (pwCnt == PW_W'(WIDE_LIM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev  <= 1'b0;
      pwCnt     <= '0;
      goodCnt   <= '0;
      periodBad <= 1'b0;
      lockFlag  <= 1'b0;
    end else begin
      modePrev <= modeSel;
      if (modeChange) begin
        pwCnt     <= '0;
        goodCnt   <= '0;
        periodBad <= 1'b0;
        lockFlag  <= 1'b0;
      end else begin
        if (!active)                     pwCnt <= '0;
        else if (pwCnt != PW_W'(WIDE_LIM)) pwCnt <= pwCnt + PW_W'(1);

        periodBad <= status.refTick ? 1'b0 : (periodBad | wideNow);

        if (wideNow) begin
          lockFlag <= 1'b0;
          goodCnt  <= '0;
        end else if (status.refTick) begin
          if (periodBad) begin
            goodCnt <= '0;
          end else if (goodCnt == GOOD_W'(LOCK_COUNT - 1)) begin
            lockFlag <= 1'b1;
          end else begin
            goodCnt <= goodCnt + GOOD_W'(1);
          end
        end
      end
    end
  end

  // R8: lock only rises right after a reference divided event
  p_lock_on_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(status.refTick));

  // R9: an over-wide pulse drops the lock flag
  p_wide_unlock_r9: assert property (@(posedge clk) disable iff (!rstN)
    wideNow |=> !lockFlag);

  // R10: a mode change drops the lock flag
  p_mode_unlock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |=> !lockFlag);

  // R7: the pump pin is never driven both ways
  p_pump_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpHigh && pumpLow));

endmodule

// File: rtl/pll_cmp_core.sv
module pll_cmp_core
  import pll_cmp_pkg::*;
#(
  parameter int VCO_DIV_HI = 338,
  parameter int REF_DIV_HI = 4,
  parameter int VCO_DIV_LO = 570,
  parameter int REF_DIV_LO = 6,
  parameter int WIDE_LIM   = 4,
  parameter int LOCK_COUNT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic vcoIn,
  input  logic refIn,
  input  logic modeSel,
  input  logic polSel,
  output logic pumpHigh,
  output logic pumpLow,
  output logic testOut,
  output logic lockFlag
);

  localparam int MAX_DIV = maxOf4(VCO_DIV_HI, REF_DIV_HI, VCO_DIV_LO, REF_DIV_LO);
  localparam int CNT_W   = $clog2(MAX_DIV);

  ctrlStrobe_t strobe;
  pfdStatus_t  status;
  logic        vcoDiv;
  logic        refDiv;

  pcc_datapath #(
    .VCO_DIV_HI(VCO_DIV_HI),
    .REF_DIV_HI(REF_DIV_HI),
    .VCO_DIV_LO(VCO_DIV_LO),
    .REF_DIV_LO(REF_DIV_LO),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .vcoIn  (vcoIn),
    .refIn  (refIn),
    .modeSel(modeSel),
    .strobe (strobe),
    .status (status),
    .vcoDiv (vcoDiv),
    .refDiv (refDiv)
  );

  pcc_control #(
    .WIDE_LIM  (WIDE_LIM),
    .LOCK_COUNT(LOCK_COUNT)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .polSel  (polSel),
    .status  (status),
    .vcoDiv  (vcoDiv),
    .refDiv  (refDiv),
    .strobe  (strobe),
    .pumpHigh(pumpHigh),
    .pumpLow (pumpLow),
    .testOut (testOut),
    .lockFlag(lockFlag)
  );

endmodule

// File: tb/pll_cmp_core_tb.sv
module pll_cmp_core_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vcoIn = 1'b0;
  logic refIn = 1'b0;
  logic modeSel = 1'b1;
  logic polSel = 1'b1;
  logic pumpHigh, pumpLow, testOut, lockFlag;

  int checks = 0;
  int fails = 0;

  // stimulus generator state
  logic genRun = 1'b0;
  int vPer = 2, rPer = 169, rDly = 0;
  int vPh = 0, rPh = 0, rWait = 0;

  always #10ns clk = ~clk;

  pll_cmp_core u_dut (
    .clk(clk), .rstN(rstN), .vcoIn(vcoIn), .refIn(refIn),
    .modeSel(modeSel), .polSel(polSel),
    .pumpHigh(pumpHigh), .pumpLow(pumpLow), .testOut(testOut), .lockFlag(lockFlag)
  );

  // Periodic VCO / reference sources, updated away from the active edge
  always @(negedge clk) begin
    if (!genRun) begin
      vcoIn = 1'b0; refIn = 1'b0;
      vPh = vPer - 1; rPh = rPer - 1; rWait = rDly;
    end else begin
      vPh = (vPh + 1) % vPer;
      vcoIn = (vPh < vPer / 2);
      if (rWait > 0) rWait = rWait - 1;
      else begin
        rPh = (rPh + 1) % rPer;
        refIn = (rPh < rPer / 2);
      end
    end
  end

  typedef struct packed {
    bit mode; bit pol;
    int vp; int rp; int rd; int win;
    bit expHi; bit expLo; bit expLock;
  } row_t;

  // mode, pol, vcoPer, refPer, refDelay, window, pumpHigh seen, pumpLow seen, locked
  localparam row_t ROWS [10] = '{
    '{1'b1, 1'b1, 2, 169, 167, 6760,  1'b0, 1'b0, 1'b1}, // R7 R8 aligned
    '{1'b1, 1'b0, 2, 169, 167, 6760,  1'b0, 1'b0, 1'b1}, // R7 R8 aligned
    '{1'b1, 1'b1, 2, 150, 0,   3000,  1'b0, 1'b1, 1'b0}, // R5 ref fast
    '{1'b1, 1'b0, 2, 150, 0,   3000,  1'b1, 1'b0, 1'b0}, // R6 ref fast
    '{1'b1, 1'b1, 2, 190, 200, 3500,  1'b1, 1'b0, 1'b0}, // R5 ref slow
    '{1'b1, 1'b0, 2, 190, 200, 3500,  1'b0, 1'b1, 1'b0}, // R6 ref slow
    '{1'b0, 1'b1, 2, 190, 188, 11400, 1'b0, 1'b0, 1'b1}, // R2 R8 aligned
    '{1'b0, 1'b1, 2, 170, 0,   5000,  1'b0, 1'b1, 1'b0}, // R2 R5 ref fast
    '{1'b1, 1'b1, 2, 169, 169, 6760,  1'b1, 1'b0, 1'b1}, // R8 narrow lag
    '{1'b1, 1'b1, 2, 169, 187, 6760,  1'b1, 1'b0, 1'b0}  // R8 wide lag
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startRun(input bit m, input bit p, input int vp, input int rp, input int rd);
    @(negedge clk);
    genRun = 1'b0; rstN = 1'b0;
    modeSel = m; polSel = p; vPer = vp; rPer = rp; rDly = rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    genRun = 1'b1;
  endtask

  // cycles between two rising edges of testOut, and the high time in between
  task automatic measure(output int period, output int highLen);
    int t;
    t = 0;
    @(posedge clk); #1;
    while (testOut) begin @(posedge clk); #1; end
    while (!testOut) begin @(posedge clk); #1; end
    highLen = 0; period = 0;
    while (testOut) begin @(posedge clk); #1; highLen++; period++; end
    while (!testOut) begin @(posedge clk); #1; period++; end
    t = period;
    period = t;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int per, hl, nHi, nLo;

    // R11 reset state
    startRun(1'b1, 1'b1, 2, 169, 167);
    #1;
    check(!pumpHigh && !pumpLow, "R11 pumps idle", {pumpHigh, pumpLow}, 0);
    check(lockFlag == 1'b0, "R11 lock low", lockFlag, 0);
    check(testOut == 1'b1, "R11 testOut high", testOut, 1);

    // Vector table
    foreach (ROWS[i]) begin
      startRun(ROWS[i].mode, ROWS[i].pol, ROWS[i].vp, ROWS[i].rp, ROWS[i].rd);
      nHi = 0; nLo = 0;
      for (int c = 0; c < ROWS[i].win; c++) begin
        @(posedge clk); #1;
        if (pumpHigh) nHi++;
        if (pumpLow) nLo++;
        if (pumpHigh && pumpLow) check(1'b0, "R7 both pumps", 1, 0);
      end
      check((nHi > 0) == ROWS[i].expHi, $sformatf("R5 R6 row%0d pumpHigh seen", i), nHi, int'(ROWS[i].expHi));
      check((nLo > 0) == ROWS[i].expLo, $sformatf("R5 R6 row%0d pumpLow seen", i), nLo, int'(ROWS[i].expLo));
      check(lockFlag == ROWS[i].expLock, $sformatf("R8 row%0d lock", i), lockFlag, int'(ROWS[i].expLock));
    end

    // R1 R4 reference divider /4 on testOut, period 4*150
    startRun(1'b1, 1'b1, 2, 150, 0);
    measure(per, hl);
    check(per == 600, "R1 R4 ref ratio period", per, 600);
    check(hl == 300, "R3 ref half high", hl, 300);
    // R1 R4 VCO divider /338 on testOut, period 338*2
    startRun(1'b1, 1'b0, 2, 150, 0);
    measure(per, hl);
    check(per == 676, "R1 R4 vco ratio period", per, 676);
    // R2 reference /6 and VCO /570
    startRun(1'b0, 1'b1, 2, 170, 0);
    measure(per, hl);
    check(per == 1020, "R2 ref ratio period", per, 1020);
    check(hl == 510, "R3 ref half high mode0", hl, 510);
    startRun(1'b0, 1'b0, 2, 170, 0);
    measure(per, hl);
    check(per == 1140, "R2 vco ratio period", per, 1140);

    // R8 lock timing: eighth ref event at cycle ~5406
    startRun(1'b1, 1'b1, 2, 169, 167);
    repeat (4000) @(posedge clk); #1;
    check(lockFlag == 1'b0, "R8 not yet locked", lockFlag, 0);
    repeat (2500) @(posedge clk); #1;
    check(lockFlag == 1'b1, "R8 locked", lockFlag, 1);

    // R9 frequency step breaks lock
    @(negedge clk); rPer = 150;
    repeat (1500) @(posedge clk); #1;
    check(lockFlag == 1'b0, "R9 wide pulse unlock", lockFlag, 0);

    // R10 mode flip clears lock and counters
    startRun(1'b1, 1'b1, 2, 169, 167);
    repeat (6500) @(posedge clk); #1;
    check(lockFlag == 1'b1, "R10 precondition lock", lockFlag, 1);
    @(negedge clk); modeSel = 1'b0;
    repeat (2) @(posedge clk); #1;
    check(lockFlag == 1'b0, "R10 lock cleared", lockFlag, 0);
    check(testOut == 1'b1, "R10 count restarted", testOut, 1);
    check(!pumpHigh && !pumpLow, "R10 detector cleared", {pumpHigh, pumpLow}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule